// File: doc/BRIEF.md
# I2C Byte Shifter with Framing and Acknowledge Check

This block is the byte-level data path of an I2C master. A transmit shifter pulls the SDA line low through an open-drain output enable, and a receive shifter samples the line. Both shifters are stepped by a shift-clock level that comes from an external baud timer. That level first passes through a two-flop synchronizer. The transmit side moves on each rising transition of the synchronized clock. The receive side samples on each falling transition.

A word starts when the transmit buffer holds a byte and no word is in flight. The shifter first drives a leading low bit. It then puts the data out most significant bit first, one bit per rising strobe. On the ninth rising strobe it releases the line for the acknowledge slot. The receive side captures the eight data bits on the first eight falling strobes and reads the acknowledge slot on the ninth. It then copies the byte to a read buffer. A high level in the acknowledge slot raises an error flag.

The controlling agent generates START, STOP and repeated START. After a NACK, it writes 0x00 to hold SDA low, which prepares a STOP, or 0xFF to leave SDA released, which prepares a repeated START. It then stops the baud timer when it needs to. To read from a target, the agent writes 0xFF so that SDA stays released while the target drives the data bits.

Top module: `i2c_frame_shifter`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, nack_err is 0 and sda_oe is 0 (SDA released).
- R2: A wr_en pulse stores wr_data and clears tx_empty. When no word is in flight and the buffer is full, the byte is loaded into the shifter. The load sets tx_empty again and drives the leading bit low (sda_oe = 1) on the following cycle.
- R3: The eight data bits appear on SDA one per rising strobe, most significant bit first. A 0 bit gives sda_oe = 1 and a 1 bit gives sda_oe = 0. The ninth rising strobe releases SDA (sda_oe = 0) for the acknowledge slot.
- R4: A rising transition of shift_clk that is sampled at clock edge k changes sda_oe at edge k+1. This places the change two clock cycles after shift_clk changes.
- R5: The line is driven only low, through sda_oe. sda_oe is 0 whenever no word is in flight.
- R6: On falling strobes 1 to 8 the receive shifter samples sda_in, most significant bit first. On the ninth falling strobe the byte moves to rd_data, rx_full is set and the word ends. A rd_en pulse clears rx_full.
- R7: If sda_in is 1 at the ninth falling strobe (NACK), nack_err is set. If it is 0 (ACK), nack_err stays 0. An err_clr pulse clears nack_err.
- R8: Shift-clock transitions while no word is in flight have no effect on sda_oe, the flags or the bit sequencing of the next word.
- R9: A byte written while a word is in flight is held, with tx_empty at 0, and loads as soon as that word ends. The all-zero and all-one bytes shift like any other data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_clk | input | 1 | Shift-clock level from the baud timer |
| sda_in | input | 1 | SDA pin level |
| sda_oe | output | 1 | SDA output enable; 1 pulls the line low |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DW | Byte to transmit |
| tx_empty | output | 1 | Transmit buffer empty |
| rd_en | input | 1 | Read acknowledge; clears rx_full |
| rd_data | output | DW | Last received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| nack_err | output | 1 | NACK seen in the acknowledge slot |
| err_clr | input | 1 | Clears nack_err |

## Verification
Words are run with random transmit bytes, random target bytes and a random ACK or NACK. The bus is modelled as wired-AND, so every received byte is the AND of the master and target bytes. This exposes bit-order errors and swapped sampling edges. Directed cases use 0x00 with NACK and 0xFF with ACK to separate the STOP and repeated-START setups. A second write during a word confirms that the held byte loads only when the word ends. Strobes sent while idle must leave the next word's bit positions unchanged. Each rising strobe is observed one and two cycles after it is driven, which pins down the synchronizer latency.

// File: rtl/i2c_frame_shifter.sv
module i2c_frame_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_clk,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          tx_empty,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rx_full,
  output logic          nack_err,
  input  logic          err_clr
);
  localparam int NPOS = DW + 1;
  localparam int CW = $clog2(NPOS + 1);
  localparam logic [CW-1:0] LASTC = CW'(NPOS);

  logic          s1, s2;
  logic          busy;
  logic [CW-1:0] rise_cnt, fall_cnt;
  logic [DW:0]   tx_sr;
  logic          tx_bit;
  logic [DW-1:0] tx_buf;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] rx_buf;

  wire rise = s1 & ~s2;
  wire fall = ~s1 & s2;
  wire load = ~busy & ~tx_empty;
  wire adv  = busy & rise & (rise_cnt < LASTC);
  wire smp  = busy & fall & (fall_cnt < rise_cnt);
  wire last = smp & (fall_cnt == LASTC - CW'(1));

  assign sda_oe  = busy & ~tx_bit;
  assign rd_data = rx_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= shift_clk;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (wr_en) tx_buf <= wr_data;
      if (wr_en) tx_empty <= 1'b0;
      else if (load) tx_empty <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      rise_cnt <= '0;
      fall_cnt <= '0;
      tx_sr    <= '1;
      tx_bit   <= 1'b1;
    end else if (load) begin
      busy     <= 1'b1;
      rise_cnt <= '0;
      fall_cnt <= '0;
      tx_sr    <= {tx_buf, 1'b1};
      tx_bit   <= 1'b0;
    end else begin
      if (adv) begin
        rise_cnt <= rise_cnt + CW'(1);
        tx_bit   <= tx_sr[DW];
        tx_sr    <= {tx_sr[DW-1:0], 1'b1};
      end
      if (smp) fall_cnt <= fall_cnt + CW'(1);
      if (last) begin
        busy   <= 1'b0;
        tx_bit <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sr    <= '0;
      rx_buf   <= '0;
      rx_full  <= 1'b0;
      nack_err <= 1'b0;
    end else begin
      if (smp && !last) rx_sr <= {rx_sr[DW-2:0], sda_in};
      if (last) rx_buf <= rx_sr;
      if (last) rx_full <= 1'b1;
      else if (rd_en) rx_full <= 1'b0;
      if (last && sda_in) nack_err <= 1'b1;
      else if (err_clr) nack_err <= 1'b0;
    end
endmodule

module i2c_frame_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tx_empty,
  input logic sda_oe,
  input logic sda_in,
  input logic rx_full,
  input logic nack_err
);
  assert_load_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_empty) |=> (busy && sda_oe && tx_empty));

  assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  assert_capture_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !busy);

  assert_nack_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> ($past(sda_in) && rx_full));
endmodule

bind i2c_frame_shifter i2c_frame_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_empty(tx_empty),
  .sda_oe(sda_oe), .sda_in(sda_in), .rx_full(rx_full), .nack_err(nack_err)
);

// File: tb/i2c_frame_shifter_tb.sv
module i2c_frame_shifter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_clk = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       slv_low = 1'b0;
  logic       sda_oe, tx_empty, rx_full, nack_err;
  logic [7:0] rd_data;
  wire        sda_in = ~sda_oe & ~slv_low;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_frame_shifter #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .sda_in(sda_in),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
    .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full),
    .nack_err(nack_err), .err_clr(err_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic oe_for(input logic [7:0] b, input int k);
    if (k >= 1 && k <= 8) return ~b[8-k];
    return 1'b0;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_word(input logic [7:0] tx, input logic [7:0] slv, input logic nack,
                          input bit queue_next, input logic [7:0] nxt);
    logic prev;
    chk("R2 lead bit low", sda_oe, 1'b1);
    chk("R2 buffer empty after load", tx_empty, 1'b1);
    prev = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk); shift_clk = 1'b1;
      @(negedge clk); chk("R4 no change after one cycle", sda_oe, prev);
      @(negedge clk); chk("R3 bit on rising strobe", sda_oe, oe_for(tx, k));
      prev = oe_for(tx, k);
      slv_low = (k <= 8) ? ~slv[8-k] : ~nack;
      if (queue_next && k == 4) begin
        write_byte(nxt);
        chk("R9 held byte keeps buffer full", tx_empty, 1'b0);
      end
      @(negedge clk); shift_clk = 1'b0;
      wait_n(3);
    end
    slv_low = 1'b0;
    chk("R6 rx_full set", rx_full, 1'b1);
    chk("R6 received byte", rd_data, tx & slv);
    chk("R7 ack slot result", nack_err, nack);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R6 rd_en clears rx_full", rx_full, 1'b0);
    if (nack) begin
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R7 err_clr clears flag", nack_err, 1'b0);
    end
    if (!queue_next) begin
      chk("R5 released when idle", sda_oe, 1'b0);
      chk("R2 buffer empty idle", tx_empty, 1'b1);
    end
  endtask

  initial begin
    wait_n(200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] t, s;
    logic n;
    void'($urandom(32'h5eed1234));
    wait_n(3);
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 rx_full", rx_full, 1'b0);
    chk("R1 nack_err", nack_err, 1'b0);
    chk("R1 sda_oe", sda_oe, 1'b0);
    rst_n = 1'b1;
    wait_n(2);

    for (int i = 0; i < 3; i++) begin
      @(negedge clk); shift_clk = 1'b1;
      wait_n(4); shift_clk = 1'b0;
      wait_n(4);
      chk("R8 idle strobe no drive", sda_oe, 1'b0);
      chk("R8 idle strobe no flag", {rx_full, nack_err, tx_empty}, 3'b001);
    end

    write_byte(8'hA5);
    chk("R2 write clears tx_empty", tx_empty, 1'b0);
    @(negedge clk);
    run_word(8'hA5, 8'hFF, 1'b0, 0, 8'h00);

    write_byte(8'h00);
    @(negedge clk);
    run_word(8'h00, 8'hFF, 1'b1, 0, 8'h00);

    write_byte(8'hFF);
    @(negedge clk);
    run_word(8'hFF, 8'h3C, 1'b0, 1, 8'h81);
    wait_n(1);
    run_word(8'h81, 8'hFF, 1'b1, 0, 8'h00);

    for (int i = 0; i < 8; i++) begin
      t = 8'($urandom);
      s = 8'($urandom);
      n = 1'($urandom);
      write_byte(t);
      @(negedge clk);
      run_word(t, s, n, 0, 8'h00);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule